// File: doc/BRIEF.md
# Serial EEPROM Boot and Access Controller

This controller sits between a host register interface and a 4-wire serial EEPROM. After reset it fetches an initialization word from the EEPROM and checks a two-bit signature in it. When the signature is good, it reads a short run of configuration words into internal registers. When the signature is bad, the part is treated as absent and no further words are read.

Once that boot load is finished, the host can fetch any single word through a read port that has address, start, done and data fields. Software can also take over the EEPROM pins bit by bit through a request/grant handshake.

Each hardware read is one serial frame, built as follows:
- The controller raises chip select.
- It shifts out a `1` start bit, then the opcode `10`, then the word address MSB first.
- It shifts in 16 data bits MSB first.
- It lowers chip select.

The shift clock comes from a divider on the system clock. Each half period lasts `DIV` system clocks, and input bits are sampled on the rising shift-clock edge.

Top module: `eeprom_boot_ctrl`

## Requirements
- R1: After reset the first frame reads word address `ICW_ADDR` (default 10). Every frame consists of cs high, then start bit 1, opcode bits 1 then 0, the address MSB first, and 16 data bits MSB first sampled at rising `ee_sk`, followed by cs low.
- R2: If bits 15:14 of the initialization word equal `01`, the block reads `CFG_N` words at addresses `CFG_BASE`, `CFG_BASE+1`, and so on upward. Word i lands in `cfg_data[16i+15:16i]`. `cfg_valid` and `boot_done` then go to 1.
- R3: Any other signature value ends the boot after that single frame, with `boot_done`=1, `cfg_valid`=0 and `cfg_data`=0.
- R4: A one-cycle `rd_start` with `rd_addr` fetches that word into `rd_data` and sets `rd_done`.
- R5: `rd_done` reads 0 in the cycle after any `rd_start`.
- R6: Host reads never change `cfg_data`, even when they read configuration addresses whose contents have since changed.
- R7: `sw_grant` is 0 until `boot_done` is set and 0 while a hardware frame runs. It rises once `sw_req` is 1 and the engine is idle, and it falls in the cycle after `sw_req` goes to 0.
- R8: While `sw_grant` is 1, `ee_cs`, `ee_sk` and `ee_di` equal `sw_cs`, `sw_sk` and `sw_di`. `sw_do` always mirrors `ee_do`.
- R9: A `rd_start` arriving during boot or during grant is held and served once the engine is free. While it waits, `rd_done` stays 0.
- R10: `ee_rst`=1 resets the block exactly as `rst_n`=0 does (`boot_done`, `rd_done`, `sw_grant`, `ee_cs` all 0), and the boot load runs again.
- R11: Each high phase of the engine's `ee_sk` lasts `DIV` system clocks, and `ee_sk` is low whenever the engine raises `ee_cs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ee_rst | input | 1 | Soft reset; restarts the boot load |
| rd_start | input | 1 | One-cycle start of a host word read |
| rd_addr | input | AW | Word address for the host read |
| rd_done | output | 1 | Host read finished |
| rd_data | output | 16 | Word from the last host read |
| sw_req | input | 1 | Software asks for direct pin control |
| sw_grant | output | 1 | Direct pin control granted |
| sw_cs | input | 1 | Software chip select |
| sw_sk | input | 1 | Software shift clock |
| sw_di | input | 1 | Software data to EEPROM |
| sw_do | output | 1 | EEPROM data out, mirrored |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM shift clock |
| ee_di | output | 1 | Serial data to EEPROM |
| ee_do | input | 1 | Serial data from EEPROM |
| boot_done | output | 1 | Boot load finished |
| cfg_valid | output | 1 | Signature was good and configuration was loaded |
| cfg_data | output | CFG_N*16 | Loaded configuration words |

## Verification
A wrong bit counter or a wrong shift-register state corrupts a frame. The bench's EEPROM model then decodes a bad opcode or address, or returns a word that differs from the one computed in the bench, and this shows within one frame, roughly `(AW+19)*2*DIV` clocks. A wrong sequencer state shows up in several ways:
- an extra or missing boot frame;
- the wrong `cfg_data` slot being filled;
- `rd_done` never setting, which is caught by a bounded wait.

A grant register that is out of step with the engine shows as `sw_grant` high during a frame or before `boot_done`, which is visible on the very next cycle.

// File: rtl/eeprom_boot_ctrl.sv
module eeprom_boot_ctrl #(
  parameter int AW       = 6,
  parameter int DIV      = 2,
  parameter int ICW_ADDR = 10,
  parameter int CFG_BASE = 11,
  parameter int CFG_N    = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ee_rst,
  input  logic                  rd_start,
  input  logic [AW-1:0]         rd_addr,
  output logic                  rd_done,
  output logic [15:0]           rd_data,
  input  logic                  sw_req,
  output logic                  sw_grant,
  input  logic                  sw_cs,
  input  logic                  sw_sk,
  input  logic                  sw_di,
  output logic                  sw_do,
  output logic                  ee_cs,
  output logic                  ee_sk,
  output logic                  ee_di,
  input  logic                  ee_do,
  output logic                  boot_done,
  output logic                  cfg_valid,
  output logic [CFG_N*16-1:0]   cfg_data
);
  localparam int NOUT = AW + 3;
  localparam int NB   = NOUT + 16;
  localparam int BW   = $clog2(NB);
  localparam int DW   = $clog2(DIV) + 1;
  localparam int IW   = $clog2(CFG_N) + 1;

  typedef enum logic [1:0] {ST_ICW, ST_CFG, ST_IDLE, ST_HOST} st_t;

  st_t                st;
  logic               rst, run, ph, sk_q, pend, grant_q, done_q, sig_q, boot_q;
  logic               tick, last, launch;
  logic [DW-1:0]      dc;
  logic [BW-1:0]      bc;
  logic [NOUT-1:0]    tx;
  logic [15:0]        rx, data_q;
  logic [AW-1:0]      paddr, laddr;
  logic [IW-1:0]      idx;
  logic [CFG_N*16-1:0] cfg_q;

  assign rst    = !rst_n || ee_rst;
  assign tick   = run && dc == DW'(DIV - 1);
  assign last   = tick && ph && bc == BW'(NB - 1);
  assign launch = !run && (st == ST_ICW || st == ST_CFG ||
                           (st == ST_IDLE && pend && !grant_q));

  always_comb begin
    case (st)
      ST_ICW:  laddr = AW'(ICW_ADDR);
      ST_CFG:  laddr = AW'(CFG_BASE) + AW'(idx);
      default: laddr = paddr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      ph   <= 1'b0;
      sk_q <= 1'b0;
      dc   <= '0;
      bc   <= '0;
      tx   <= '0;
      rx   <= '0;
    end else if (launch) begin
      run  <= 1'b1;
      ph   <= 1'b0;
      sk_q <= 1'b0;
      dc   <= '0;
      bc   <= '0;
      tx   <= {3'b110, laddr};
    end else if (run) begin
      if (tick) begin
        dc <= '0;
        if (!ph) begin
          ph   <= 1'b1;
          sk_q <= 1'b1;
          if (bc >= BW'(NOUT)) rx <= {rx[14:0], ee_do};
        end else begin
          ph   <= 1'b0;
          sk_q <= 1'b0;
          if (bc == BW'(NB - 1)) begin
            run <= 1'b0;
          end else begin
            bc <= bc + 1'b1;
            tx <= {tx[NOUT-2:0], 1'b0};
          end
        end
      end else begin
        dc <= dc + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_ICW;
      idx     <= '0;
      cfg_q   <= '0;
      sig_q   <= 1'b0;
      boot_q  <= 1'b0;
      pend    <= 1'b0;
      paddr   <= '0;
      done_q  <= 1'b0;
      data_q  <= '0;
      grant_q <= 1'b0;
    end else begin
      grant_q <= sw_req && st == ST_IDLE && (grant_q || !pend);
      if (rd_start) begin
        pend   <= 1'b1;
        paddr  <= rd_addr;
        done_q <= 1'b0;
      end else if (launch && st == ST_IDLE) begin
        pend <= 1'b0;
      end
      if (launch && st == ST_IDLE) st <= ST_HOST;
      if (last) begin
        case (st)
          ST_ICW: begin
            if (rx[15:14] == 2'b01) begin
              sig_q <= 1'b1;
              idx   <= '0;
              st    <= ST_CFG;
            end else begin
              boot_q <= 1'b1;
              st     <= ST_IDLE;
            end
          end
          ST_CFG: begin
            cfg_q[idx*16 +: 16] <= rx;
            if (idx == IW'(CFG_N - 1)) begin
              boot_q <= 1'b1;
              st     <= ST_IDLE;
            end else begin
              idx <= idx + 1'b1;
            end
          end
          ST_HOST: begin
            data_q <= rx;
            st     <= ST_IDLE;
            if (!rd_start && !pend) done_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign sw_grant  = grant_q;
  assign sw_do     = ee_do;
  assign ee_cs     = grant_q ? sw_cs : run;
  assign ee_sk     = grant_q ? sw_sk : sk_q;
  assign ee_di     = grant_q ? sw_di : (run && tx[NOUT-1]);
  assign rd_done   = done_q;
  assign rd_data   = data_q;
  assign boot_done = boot_q;
  assign cfg_valid = sig_q && boot_q;
  assign cfg_data  = cfg_q;
endmodule

// File: rtl/eeprom_boot_ctrl_chk.sv
module eeprom_boot_ctrl_chk #(
  parameter int W = 48
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ee_rst,
  input logic         rd_start,
  input logic         rd_done,
  input logic         sw_req,
  input logic         sw_grant,
  input logic         ee_cs,
  input logic         ee_sk,
  input logic         boot_done,
  input logic [W-1:0] cfg_data
);
  a_r7_grant_after_boot: assert property (@(posedge clk) disable iff (!rst_n || ee_rst)
    sw_grant |-> boot_done);

  a_r7_grant_drop: assert property (@(posedge clk) disable iff (!rst_n || ee_rst)
    !sw_req |=> !sw_grant);

  a_r5_done_clear: assert property (@(posedge clk) disable iff (!rst_n || ee_rst)
    rd_start |=> !rd_done);

  a_r6_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n || ee_rst)
    $past(boot_done) && !$past(ee_rst) |-> $stable(cfg_data));

  a_r11_cs_rise_sk_low: assert property (@(posedge clk) disable iff (!rst_n || ee_rst)
    $rose(ee_cs) && !sw_grant |-> !ee_sk);
endmodule

bind eeprom_boot_ctrl eeprom_boot_ctrl_chk #(.W(CFG_N*16)) chk_i (
  .clk(clk), .rst_n(rst_n), .ee_rst(ee_rst), .rd_start(rd_start), .rd_done(rd_done),
  .sw_req(sw_req), .sw_grant(sw_grant), .ee_cs(ee_cs), .ee_sk(ee_sk),
  .boot_done(boot_done), .cfg_data(cfg_data)
);

// File: tb/eeprom_boot_ctrl_tb.sv
module eeprom_boot_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int AW = 6, DIV = 2, ICW = 10, CB = 11, CN = 3;
  localparam int NOUT = AW + 3;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst_n, ee_rst, rd_start, rd_done, sw_req, sw_grant, sw_cs, sw_sk, sw_di, sw_do;
  logic ee_cs, ee_sk, ee_di, ee_do, boot_done, cfg_valid;
  logic [AW-1:0] rd_addr;
  logic [15:0] rd_data;
  logic [CN*16-1:0] cfg_data;

  eeprom_boot_ctrl #(.AW(AW), .DIV(DIV), .ICW_ADDR(ICW), .CFG_BASE(CB), .CFG_N(CN)) dut_i (
    .clk(clk), .rst_n(rst_n), .ee_rst(ee_rst), .rd_start(rd_start), .rd_addr(rd_addr),
    .rd_done(rd_done), .rd_data(rd_data), .sw_req(sw_req), .sw_grant(sw_grant),
    .sw_cs(sw_cs), .sw_sk(sw_sk), .sw_di(sw_di), .sw_do(sw_do), .ee_cs(ee_cs),
    .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do), .boot_done(boot_done),
    .cfg_valid(cfg_valid), .cfg_data(cfg_data));

  int checks = 0, fails = 0;
  logic [15:0] mem [0:63];
  int m_cnt = 0, m_frames = 0, m_bad = 0;
  int m_log [0:15];
  logic [NOUT-1:0] m_cmd = '0;
  logic [15:0] m_word = '0;
  logic m_do = 1'b0;
  assign ee_do = m_do;

  always @(negedge ee_cs) m_cnt = 0;
  always @(posedge ee_sk) if (ee_cs) begin
    m_cnt++;
    if (m_cnt <= NOUT) begin
      m_cmd = {m_cmd[NOUT-2:0], ee_di};
      if (m_cnt == NOUT) begin
        if (m_cmd[NOUT-1:NOUT-3] != 3'b110) m_bad++;
        m_word = mem[m_cmd[AW-1:0]];
        if (m_frames < 16) m_log[m_frames] = int'(m_cmd[AW-1:0]);
        m_frames++;
        m_do = m_word[15];
      end
    end else begin
      m_word = {m_word[14:0], 1'b0};
      m_do = m_word[15];
    end
  end

  int hi_len = 0, sk_bad = 0, sk_seen = 0;
  always @(negedge clk) begin
    if (ee_sk && !sw_grant) hi_len++;
    else if (hi_len > 0) begin
      if (hi_len != DIV) sk_bad++;
      sk_seen++;
      hi_len = 0;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [CN*16-1:0] exp_cfg();
    logic [CN*16-1:0] v;
    for (int i = 0; i < CN; i++) v[i*16 +: 16] = mem[CB+i];
    return v;
  endfunction

  task automatic wait_boot();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (boot_done) break;
    end
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (rd_done) break;
    end
  endtask

  task automatic host_read(input int a, output logic [15:0] d);
    @(negedge clk);
    rd_start = 1'b1;
    rd_addr = AW'(a);
    @(negedge clk);
    rd_start = 1'b0;
    chk("R5 done cleared by start", 64'(rd_done), 64'(0));
    wait_done();
    d = rd_data;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [CN*16-1:0] saved;
    int gbad, fr0;
    for (int a = 0; a < 64; a++) mem[a] = 16'(a * 16'h0B3D) ^ 16'h5A3C;
    mem[ICW] = {2'b01, 14'h1234};
    rst_n = 1'b0; ee_rst = 1'b0; rd_start = 1'b0; rd_addr = '0;
    sw_req = 1'b1; sw_cs = 1'b0; sw_sk = 1'b0; sw_di = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 reset state", 64'({boot_done, rd_done, sw_grant, ee_cs}), 64'(0));
    rst_n = 1'b1;

    gbad = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (i == 20) begin rd_start = 1'b1; rd_addr = 6'd5; end
      if (i == 21) rd_start = 1'b0;
      if (sw_grant && !boot_done) gbad++;
      if (boot_done) break;
    end
    chk("R7 no grant during boot", 64'(gbad), 64'(0));
    chk("R2 boot done valid", 64'({boot_done, cfg_valid}), 64'(3));
    chk("R2 cfg data", 64'(cfg_data), 64'(exp_cfg()));
    chk("R2 boot frame count", 64'(m_frames), 64'(1 + CN));
    for (int i = 0; i <= CN; i++) chk("R1 R2 boot address order", 64'(m_log[i]), 64'(ICW + i));
    chk("R1 frame start and opcode", 64'(m_bad), 64'(0));
    wait_done();
    chk("R9 read held through boot", 64'({rd_done, rd_data}), 64'({1'b1, mem[5]}));
    repeat (2) @(negedge clk);
    chk("R7 grant after idle", 64'(sw_grant), 64'(1));

    for (int v = 0; v < 8; v++) begin
      {sw_cs, sw_sk, sw_di} = 3'(v);
      @(negedge clk);
      chk("R8 pins follow software", 64'({ee_cs, ee_sk, ee_di}), 64'(v));
    end
    {sw_cs, sw_sk, sw_di} = 3'b000;
    @(negedge clk);
    m_do = 1'b1; #1;
    chk("R8 data out mirror high", 64'(sw_do), 64'(1));
    m_do = 1'b0; #1;
    chk("R8 data out mirror low", 64'(sw_do), 64'(0));

    fr0 = m_frames;
    rd_start = 1'b1; rd_addr = 6'd20;
    @(negedge clk);
    rd_start = 1'b0;
    repeat (300) @(negedge clk);
    chk("R9 read held during grant", 64'({rd_done, sw_grant, m_frames == fr0}), 64'(3'b011));
    sw_req = 1'b0;
    @(negedge clk);
    chk("R7 grant drops after release", 64'(sw_grant), 64'(0));
    wait_done();
    chk("R9 held read served", 64'({rd_done, rd_data}), 64'({1'b1, mem[20]}));

    saved = exp_cfg();
    for (int i = 0; i < CN; i++) mem[CB+i] = ~mem[CB+i];
    for (int a = 0; a < 64; a++) begin
      host_read(a, d);
      chk("R4 host read word", 64'({rd_done, d}), 64'({1'b1, mem[a]}));
    end
    chk("R6 cfg untouched by host reads", 64'(cfg_data), 64'(saved));

    host_read(7, d);
    @(negedge clk);
    rd_start = 1'b1; rd_addr = 6'd9;
    @(negedge clk);
    rd_start = 1'b0;
    sw_req = 1'b1;
    gbad = 0;
    for (int i = 0; i < 2000; i++) begin
      if (sw_grant) gbad++;
      if (rd_done) break;
      @(negedge clk);
    end
    chk("R7 no grant during host frame", 64'(gbad), 64'(0));
    chk("R4 read before grant", 64'(rd_data), 64'(mem[9]));
    repeat (2) @(negedge clk);
    chk("R7 grant after host frame", 64'(sw_grant), 64'(1));
    sw_req = 1'b0;
    repeat (2) @(negedge clk);

    for (int s = 0; s < 4; s++) begin
      mem[ICW] = {2'(s), 14'h0ABC};
      m_frames = 0;
      ee_rst = 1'b1;
      @(negedge clk);
      ee_rst = 1'b0;
      chk("R10 soft reset state", 64'({boot_done, rd_done, sw_grant, ee_cs}), 64'(0));
      wait_boot();
      chk("R2 R3 boot done", 64'(boot_done), 64'(1));
      chk("R2 R3 cfg valid", 64'(cfg_valid), 64'(s == 1));
      chk("R2 R3 frame count", 64'(m_frames), 64'(s == 1 ? 1 + CN : 1));
      chk("R2 R3 cfg contents", 64'(cfg_data), s == 1 ? 64'(exp_cfg()) : 64'(0));
      repeat (5) @(negedge clk);
      chk("R3 no extra frames", 64'(m_frames), 64'(s == 1 ? 1 + CN : 1));
    end

    chk("R11 sk high phases seen", 64'(sk_seen > 100), 64'(1));
    chk("R11 sk high length", 64'(sk_bad), 64'(0));
    chk("R1 all frames well formed", 64'(m_bad), 64'(0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule